// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave has left stuck, and is run once before the master engine that shares the bus is put to use. A one-cycle start request launches a fixed sequence. The block first strobes a clear of the engine's sticky status flags. It then holds the engine in soft reset and checks whether both bus lines read high. While the bus is not free, it pulls the clock line low for one phase and releases it for one phase, then checks again. Each phase lasts a fixed number of timing ticks, which gives roughly 10 µs at a 1 MHz tick. After a bounded number of pulses it gives up. In either case it releases the soft reset and reports completion, with a failure flag when the bus never came free.

Both line samples pass through a multi-flop synchronizer before any decision is taken. The block only ever asks for a line to be pulled low through open-drain enables. It never drives a line high. The data line is never pulled at all: it is left released so that the stuck slave can finish shifting out its byte and let go.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, every output (both drive enables, soft reset, status clear, done, fail) is low.
- R2: A start request seen while the block is idle gives exactly one status-clear pulse, one cycle wide, in the cycle after the request. The first clock pull-down comes after it.
- R3: The soft-reset output is high from the status-clear cycle through every cycle until done. It is low in the done cycle and while idle.
- R4: If the synchronized lines are both high at the first check, done rises with fail low and no clock pulse. This is 3 cycles after the start request is sampled.
- R5: The bus counts as free only when both lines are high. A clock line held low by another device with the data line high is treated as a stuck bus.
- R6: Each failed check is followed by one clock pulse. The clock enable is high for PHASE_TICKS ticks and then low for PHASE_TICKS ticks, and then the bus is checked again. With a tick on every cycle, one pulse adds 2*PHASE_TICKS+1 cycles.
- R7: At most MAX_TRIES pulses are issued. If the check after the last pulse still finds the bus busy, done rises together with fail.
- R8: The data-line enable is never asserted. The clock-line enable is only asserted during a pulse's low phase, inside a sequence.
- R9: Done is a single-cycle pulse and fail is high only together with done. A start request made while a sequence runs is ignored and does not restart it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a recovery sequence (sampled when idle) |
| tick_i | input | 1 | Timing tick; PHASE_TICKS of them make one clock phase |
| scl_in | input | 1 | Raw sample of the bus clock pin |
| sda_in | input | 1 | Raw sample of the bus data pin |
| scl_drive_o | output | 1 | Open-drain pull-down enable for the clock pin |
| sda_drive_o | output | 1 | Open-drain pull-down enable for the data pin |
| engine_rst_o | output | 1 | Soft reset held on the master engine |
| status_clr_o | output | 1 | One-cycle strobe clearing the engine's sticky status |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Bus still stuck; valid with done_o |

## Verification
The assertions check the cycle-level rules on every cycle: the status-clear pulse after an idle start, soft reset held across the whole sequence, clock pull-down confined to a running sequence, the bound on the number of pulses, and fail appearing only with a single-cycle done. Only the bench scenarios can show the outcomes. A slave models a data line stuck for a given number of pulses, and the bench sweeps that number across and past the attempt limit at two tick rates. It checks the exact pulse count, the phase widths, the success or failure verdict and the total latency, and it also covers a clock line held low and a start request issued mid-sequence.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_CHECK,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } rec_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_pins_t;

    localparam int PIN_W = $bits(bus_pins_t);

    function automatic logic bus_free(input bus_pins_t p);
        return p.scl & p.sda;
    endfunction

    function automatic logic holds_reset(input rec_state_e s);
        return (s == ST_CLEAR) || (s == ST_CHECK) || (s == ST_LOW) || (s == ST_HIGH);
    endfunction

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '1;
            end else if (g == 0) begin
                stage_q[g] <= din;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/busrec_phase_timer.sv
module busrec_phase_timer #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic expired
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expired = en && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || expired) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
    import busrec_pkg::*;
#(
    parameter int PHASE_TICKS = 10,
    parameter int MAX_TRIES   = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_drive_o,
    output logic sda_drive_o,
    output logic engine_rst_o,
    output logic status_clr_o,
    output logic done_o,
    output logic fail_o
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES);

    rec_state_e state_q, state_d;
    logic [TW-1:0] tries_q, tries_d;
    logic fail_q, fail_d;
    bus_pins_t raw_pins, seen_pins;
    logic [PIN_W-1:0] seen_vec;
    logic phase_end, timer_en;

    assign raw_pins = '{scl: scl_in, sda: sda_in};

    busrec_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_pins),
        .dout (seen_vec)
    );
    assign seen_pins = bus_pins_t'(seen_vec);

    assign timer_en = (state_q == ST_LOW) || (state_q == ST_HIGH);

    busrec_phase_timer #(.TICKS(PHASE_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (timer_en),
        .tick    (tick_i),
        .expired (phase_end)
    );

    always_comb begin
        state_d = state_q;
        tries_d = tries_q;
        fail_d  = fail_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CLEAR;
            ST_CLEAR: begin
                tries_d = '0;
                fail_d  = 1'b0;
                state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (bus_free(seen_pins)) begin
                    state_d = ST_FINISH;
                end else if (tries_q == TRY_LAST) begin
                    fail_d  = 1'b1;
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW:    if (phase_end) state_d = ST_HIGH;
            ST_HIGH: begin
                if (phase_end) begin
                    tries_d = tries_q + 1'b1;
                    state_d = ST_CHECK;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tries_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tries_q <= tries_d;
            fail_q  <= fail_d;
        end
    end

    assign scl_drive_o  = (state_q == ST_LOW);
    assign sda_drive_o  = 1'b0;
    assign engine_rst_o = holds_reset(state_q);
    assign status_clr_o = (state_q == ST_CLEAR);
    assign done_o       = (state_q == ST_FINISH);
    assign fail_o       = (state_q == ST_FINISH) && fail_q;
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
    parameter int MAX_TRIES = 100
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic scl_drive_o,
    input logic engine_rst_o,
    input logic status_clr_o,
    input logic done_o,
    input logic fail_o
);
    logic busy_q;
    logic drv_q;
    logic [15:0] pulse_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            drv_q       <= 1'b0;
            pulse_cnt_q <= '0;
        end else begin
            drv_q <= scl_drive_o;
            if (status_clr_o) busy_q <= 1'b1;
            else if (done_o)  busy_q <= 1'b0;
            if (status_clr_o) pulse_cnt_q <= '0;
            else if (scl_drive_o && !drv_q) pulse_cnt_q <= pulse_cnt_q + 1'b1;
        end
    end

    p_clr_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !status_clr_o && !done_o && start_i) |=> status_clr_o);

    p_clr_single_r2: assert property (@(posedge clk) disable iff (rst)
        status_clr_o |=> !status_clr_o);

    p_rst_held_r3: assert property (@(posedge clk) disable iff (rst)
        ((busy_q && !done_o) || status_clr_o) |-> engine_rst_o);

    p_rst_dropped_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !engine_rst_o);

    p_pulse_bound_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt_q <= 16'(MAX_TRIES));

    p_scl_in_seq_r8: assert property (@(posedge clk) disable iff (rst)
        scl_drive_o |-> (busy_q && engine_rst_o));

    p_fail_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> done_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .scl_drive_o  (scl_drive_o),
    .engine_rst_o (engine_rst_o),
    .status_clr_o (status_clr_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
);

// File: tb/i2c_bus_recover_tb.sv
module i2c_bus_recover_tb;
    localparam int PHASE = 3;
    localparam int MAXT  = 4;
    localparam int LIMIT = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic tick_i = 1'b1;
    logic sda_in = 1'b1;
    logic scl_hold = 1'b0;
    logic scl_in;
    logic scl_drive_o, sda_drive_o, engine_rst_o, status_clr_o, done_o, fail_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign scl_in = !scl_drive_o && !scl_hold;

    i2c_bus_recover #(.PHASE_TICKS(PHASE), .MAX_TRIES(MAXT), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .tick_i       (tick_i),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .scl_drive_o  (scl_drive_o),
        .sda_drive_o  (sda_drive_o),
        .engine_rst_o (engine_rst_o),
        .status_clr_o (status_clr_o),
        .done_o       (done_o),
        .fail_o       (fail_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input int k, input int per, input bit hold, input bit mid_start);
        int cyc = 0, clr_cnt = 0, clr_cyc = -1, pulses = 0, releases = 0;
        int done_cyc = -1, run = 0, wmin = 1 << 20, wmax = 0;
        int exp_p, wlo, whi;
        bit exp_fail, got_fail = 0, prev_drv = 0, rst_bad = 0, sda_bad = 0, scl_early = 0;
        bit idle_bad = 0;
        @(negedge clk);
        scl_hold = hold;
        sda_in   = (k == 0);
        start_i  = 1'b1;
        tick_i   = (per == 1);
        while (done_cyc < 0 && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            start_i = (mid_start && cyc == 5);
            tick_i  = (per == 1) || ((cyc % per) == per - 1);
            if (status_clr_o) begin clr_cnt++; if (clr_cyc < 0) clr_cyc = cyc; end
            if (sda_drive_o) sda_bad = 1;
            if (scl_drive_o && clr_cyc < 0) scl_early = 1;
            if (scl_drive_o && !prev_drv) pulses++;
            if (scl_drive_o) run++;
            if (!scl_drive_o && prev_drv) begin
                releases++;
                if (run < wmin) wmin = run;
                if (run > wmax) wmax = run;
                run = 0;
            end
            sda_in = (releases >= k);
            if (done_o) begin
                done_cyc = cyc;
                got_fail = fail_o;
                if (engine_rst_o) rst_bad = 1;
            end else if (!engine_rst_o) begin
                rst_bad = 1;
            end
            prev_drv = scl_drive_o;
        end
        start_i = 1'b0;
        if (done_cyc < 0) begin
            chk(0, "R7", "watchdog: sequence never finished", cyc, LIMIT);
            return;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done_o || status_clr_o || engine_rst_o || scl_drive_o || fail_o) idle_bad = 1;
        end
        exp_p    = hold ? MAXT : ((k < MAXT) ? k : MAXT);
        exp_fail = hold || (k > MAXT);
        chk(clr_cnt == 1 && clr_cyc == 1, "R2", "status clear count/cycle", clr_cyc, 1);
        chk(!scl_early, "R2", "clock pulled before status clear", scl_early, 0);
        chk(!rst_bad, "R3", "soft reset window", rst_bad, 0);
        chk(pulses == exp_p, hold ? "R5" : "R7", "pulse count", pulses, exp_p);
        chk(got_fail == exp_fail, hold ? "R5" : "R7", "fail flag", got_fail, exp_fail);
        chk(!sda_bad, "R8", "data line enable", sda_bad, 0);
        chk(!idle_bad, "R9", "idle after done (no restart)", idle_bad, 0);
        if (pulses > 0) begin
            wlo = (per == 1) ? PHASE : (PHASE - 1) * per + 1;
            whi = PHASE * per;
            chk(wmin >= wlo && wmax <= whi, "R6", "low phase width", wmax, whi);
        end
        if (per == 1) begin
            chk(done_cyc == 3 + exp_p * (2 * PHASE + 1), (exp_p == 0) ? "R4" : "R6",
                "cycles to done", done_cyc, 3 + exp_p * (2 * PHASE + 1));
        end
        scl_hold = 1'b0;
        sda_in   = 1'b1;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is held and just after release
        chk(!(scl_drive_o || sda_drive_o || engine_rst_o || status_clr_o || done_o || fail_o),
            "R1", "outputs during reset", 1, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!(scl_drive_o || sda_drive_o || engine_rst_o || status_clr_o || done_o || fail_o),
            "R1", "outputs after reset", 1, 0);
        // R4, R6, R7: sweep stuck length across and past the limit, two tick rates
        for (int per = 1; per <= 2; per++) begin
            for (int k = 0; k <= MAXT + 2; k++) begin
                run_seq(k, per, 1'b0, 1'b0);
            end
        end
        // R5: clock held low elsewhere, data high
        run_seq(0, 1, 1'b1, 1'b0);
        // R9: start during a running sequence
        run_seq(2, 1, 1'b0, 1'b1);
        run_seq(MAXT + 1, 1, 1'b0, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule